// File: doc/BRIEF.md
# Half-Step Sample-Rate Strobe Divider

This block turns a timebase tick that runs at twice the reference frame rate into a single sample strobe. The playback and record converters share that strobe, because they always run at the same sample rate. The divide ratio N runs from 1 to 6 in steps of one half. A rate-double input picks the output rate: either the reference rate divided by N, or twice the reference rate divided by N. With a reference rate of 44.1 kHz or 48 kHz this covers the usual audio rates from 8 kHz up to 96 kHz.

Software writes an 8-bit control byte that carries two 4-bit divider codes, one for each converter path. The block accepts the byte only when both codes are equal and within range. Otherwise it raises an error flag and keeps the divider it already has. An accepted divider, and the rate-double input, take effect only at a strobe boundary. As a result, no sample period is ever cut short or stretched.

Top module: `halfstep_rate_div`

## Requirements
- R1: A code k from 0 to 10 selects N = 1 + k/2. With the rate-double input low, consecutive strobes are exactly 2 + k ticks of `tick_2x` apart. This includes k = 10, which gives 12 ticks.
- R2: With the rate-double input high and 2 + k even, consecutive strobes are (2 + k)/2 ticks apart.
- R3: With the rate-double input high and 2 + k odd, the strobe spacing alternates between (3 + k)/2 and (1 + k)/2 ticks. The longer spacing comes first after any change of divider or mode, and the alternation carries on across rewrites of the same setting.
- R4: A write whose upper field (bits 7:4) differs from its lower field (bits 3:0) is rejected. `cfg_err` reads 1 in the clock after the write, and the strobe spacing stays unchanged.
- R5: A write with equal fields but a code above 10 (11 to 15) is rejected in the same way as R4.
- R6: An accepted write clears `cfg_err` in the next clock. The new divider governs only the periods that start after the next strobe, and the period already in progress keeps the old spacing.
- R7: `rate_dbl` is sampled only on the tick that produces a strobe. Changing it during a period, with `cfg_wr` low, changes the spacing only from the next period onward.
- R8: While `rst_n` is low, both `smp_stb` and `cfg_err` are 0. After release, the divider is N = 1 in normal mode, and the first strobe follows the first tick.
- R9: `smp_stb` is a single-clock pulse. It is high in the clock cycle that immediately follows the cycle holding the tick that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_2x | input | 1 | One-clock pulse at twice the reference frame rate |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte, playback code in 7:4, record code in 3:0 |
| rate_dbl | input | 1 | 1 selects twice the reference rate divided by N |
| smp_stb | output | 1 | Shared sample strobe |
| cfg_err | output | 1 | 1 when the most recent write was rejected |

## Verification
If the phase counter holds a wrong value, the spacing between strobes comes out too short or too long. The scoreboard catches this at the very next strobe, because it compares every period against its expected tick count. If the pending or active divider is updated at the wrong moment, the period in progress during a write takes the new spacing instead of the old one, and that period is checked on its own. A wrong odd-ratio phase in doubled mode swaps the long and short periods, so the error shows within the first two strobes after the change.

// File: rtl/hrd_pkg.sv
// Shared types for the half-step rate divider.
// Assumes nothing beyond a two-valued rate selection.
package hrd_pkg;

    typedef enum logic {
        MODE_NORM = 1'b0,
        MODE_DBL  = 1'b1
    } rate_mode_e;

endpackage

// File: rtl/hrd_cfg_check.sv
// Validates control-byte writes and holds the pending divider code.
// A write is accepted only when both path fields match and the code is
// no greater than MAX_CODE; otherwise the pending code is kept and the
// error flag is set until the next accepted write.
// Assumes cfg_wr is a single-clock write strobe.
module hrd_cfg_check #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    localparam int BYTE_W  = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] data,
    output logic [CODE_W-1:0] pend_code,
    output logic              err
);

    logic [CODE_W-1:0] hi_f;
    logic [CODE_W-1:0] lo_f;
    logic              ok;

    // Split the byte into the two path fields and decide validity.
    always_comb begin
        hi_f = data[BYTE_W-1:CODE_W];
        lo_f = data[CODE_W-1:0];
        ok   = (hi_f == lo_f) && (int'(lo_f) <= MAX_CODE);
    end

    // Capture an accepted code, or flag a rejected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code <= '0;
            err       <= 1'b0;
        end else if (wr) begin
            if (ok) begin
                pend_code <= lo_f;
                err       <= 1'b0;
            end else begin
                err       <= 1'b1;
            end
        end
    end

    // R4 R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !ok |=> err && $stable(pend_code));

    // R6
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && ok |=> !err && (pend_code == $past(lo_f)));

endmodule

// File: rtl/hrd_phase_acc.sv
// Phase accumulator that produces the sample strobe.
// The period is P = 2 + code in half-reference units. Each tick adds 1
// in normal mode and 2 in doubled mode; a strobe fires when the sum
// reaches P. The divider and mode are latched only on the strobe tick.
// A residue is carried only when the doubled mode and P are unchanged,
// so after any change an odd doubled ratio starts with the long period.
// Assumes tick is a single-clock pulse.
module hrd_phase_acc
    import hrd_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    localparam int P_MAX   = MAX_CODE + 2,
    localparam int CNT_W   = $clog2(P_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] pend_code,
    input  logic              dbl_req,
    output logic              stb
);

    logic [CNT_W-1:0] p_act;
    logic [CNT_W-1:0] p_new;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] sum;
    rate_mode_e       mode_act;
    logic             hit;
    logic             keep_res;

    // Next phase, strobe decision and residue policy.
    always_comb begin
        inc      = (mode_act == MODE_DBL) ? CNT_W'(2) : CNT_W'(1);
        sum      = cnt + inc;
        hit      = tick && (sum >= p_act);
        p_new    = CNT_W'(pend_code) + CNT_W'(2);
        keep_res = dbl_req && (mode_act == MODE_DBL) && (p_new == p_act);
    end

    // Advance the phase per tick; reload settings on the strobe tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= CNT_W'(1);
            p_act    <= CNT_W'(2);
            mode_act <= MODE_NORM;
            stb      <= 1'b0;
        end else begin
            stb <= hit;
            if (hit) begin
                p_act    <= p_new;
                mode_act <= dbl_req ? MODE_DBL : MODE_NORM;
                cnt      <= keep_res ? (sum - p_act) : '0;
            end else if (tick) begin
                cnt <= sum;
            end
        end
    end

    // R9
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(tick));

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < p_act);

    // R6 R7
    settle_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> $stable(p_act) && $stable(mode_act));

    // R1
    norm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb && (mode_act == MODE_NORM) |=> !stb);

endmodule

// File: rtl/halfstep_rate_div.sv
// Top of the half-step sample-rate strobe divider.
// It validates the control byte and produces one shared strobe for both
// converter paths from the double-reference tick.
// Assumes tick_2x and cfg_wr are single-clock pulses in the clk domain.
module halfstep_rate_div #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    localparam int BYTE_W  = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_2x,
    input  logic              cfg_wr,
    input  logic [BYTE_W-1:0] cfg_data,
    input  logic              rate_dbl,
    output logic              smp_stb,
    output logic              cfg_err
);

    logic [CODE_W-1:0] pend_code;

    hrd_cfg_check #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .data      (cfg_data),
        .pend_code (pend_code),
        .err       (cfg_err)
    );

    hrd_phase_acc #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_2x),
        .pend_code (pend_code),
        .dbl_req   (rate_dbl),
        .stb       (smp_stb)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !smp_stb && !cfg_err);

endmodule

// File: tb/sim_halfstep_rate_div.sv
`timescale 1ns/100ps
module sim_halfstep_rate_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_2x = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       rate_dbl = 1'b0;
    logic       smp_stb;
    logic       cfg_err;

    halfstep_rate_div u0 (
        .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .cfg_wr(cfg_wr),
        .cfg_data(cfg_data), .rate_dbl(rate_dbl),
        .smp_stb(smp_stb), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    expq[$];
    string tagq[$];
    event  drained;
    bit    tick_en = 1'b0;
    int    tph = 0;
    int    seen = 0;
    bit    prev_tick = 1'b0;
    bit    prev_stb = 1'b0;
    int    cyc = 0;

    // Model of the divider setting in force.
    int m_p = 2;
    bit m_dbl = 1'b0;
    bit m_ph = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int model_next();
        int r;
        if (!m_dbl) return m_p;
        if (m_p % 2 == 0) return m_p / 2;
        r = m_ph ? (m_p - 1) / 2 : (m_p + 1) / 2;
        m_ph = ~m_ph;
        return r;
    endfunction

    // Tick generator: one tick every three clocks.
    always @(posedge clk) begin
        #1;
        if (tick_en) begin
            tick_2x = (tph == 0);
            tph = (tph + 1) % 3;
        end else begin
            tick_2x = 1'b0;
        end
    end

    // Monitor: measures strobe spacing and pops expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_stb) begin
                chk(prev_tick, "R9 strobe follows tick", 0, 1);
                chk(!prev_stb, "R9 single pulse", 1, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "unexpected strobe", seen, -1);
                end else begin
                    int e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(seen == e, t, seen, e);
                    if (expq.size() == 0) -> drained;
                end
                seen = 0;
            end
            if (tick_2x) seen++;
            prev_tick = tick_2x;
            prev_stb = smp_stb;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            finish_run();
        end
    end

    // Driver: waits for the queue to drain at a strobe, then writes.
    task automatic apply(input bit do_wr, input logic [7:0] data, input bit dbl,
                         input int nper, input string tag);
        int  newp;
        bit  valid;
        while (expq.size() != 0) @(drained);
        valid = (data[7:4] == data[3:0]) && (data[3:0] <= 4'd10);
        // the period in progress keeps the old setting (R6 R7)
        expq.push_back(model_next());
        tagq.push_back({tag, " (R6 R7 old period)"});
        newp = (do_wr && valid) ? 2 + int'(data[3:0]) : m_p;
        if (newp != m_p || dbl != m_dbl) m_ph = 1'b0;
        m_p = newp;
        m_dbl = dbl;
        for (int i = 0; i < nper; i++) begin
            expq.push_back(model_next());
            tagq.push_back(tag);
        end
        @(posedge clk);
        #0.5;
        cfg_wr = do_wr;
        cfg_data = data;
        rate_dbl = dbl;
        @(posedge clk);
        #0.5;
        cfg_wr = 1'b0;
        if (do_wr)
            chk(cfg_err == !valid, valid ? "R6 error cleared" : "R4 R5 error raised",
                int'(cfg_err), int'(!valid));
    endtask

    initial begin
        repeat (5) begin
            @(negedge clk);
            chk(!smp_stb && !cfg_err, "R8 quiet in reset", int'(smp_stb | cfg_err), 0);
        end
        expq.push_back(1);
        tagq.push_back("R8 first tick strobes");
        @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        tick_en = 1'b1;

        apply(1, 8'h00, 0, 2, "R1 k=0 normal");
        apply(1, 8'h33, 0, 3, "R1 k=3 normal");
        apply(1, 8'hAA, 0, 2, "R1 k=10 normal");
        apply(1, 8'h12, 0, 2, "R4 mismatch kept");
        apply(1, 8'hBB, 0, 2, "R5 code 11 kept");
        apply(1, 8'hFF, 0, 1, "R5 code 15 kept");
        apply(1, 8'h22, 1, 3, "R2 k=2 doubled");
        apply(1, 8'h11, 1, 4, "R3 k=1 doubled");
        apply(1, 8'h11, 1, 3, "R3 rewrite keeps phase");
        apply(0, 8'h77, 0, 2, "R7 mode only");
        apply(1, 8'hAA, 1, 3, "R2 k=10 doubled");
        apply(1, 8'h99, 1, 4, "R3 k=9 doubled");
        apply(1, 8'h55, 0, 2, "R6 k=5 normal");
        while (expq.size() != 0) @(drained);
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule